// File: doc/BRIEF.md
# ECP FIFO Register Window

This block is the host-side register window of an extended-capabilities parallel port. A single byte FIFO, 16 entries deep by default, sits behind one shared register offset. A 3-bit mode input, taken from the port's extended control register, sets what that offset means. In data mode the FIFO carries bytes between the host and the peripheral transfer engine, and a direction input decides which side fills it and which side drains it. In test mode the host can push and pop freely, whatever the direction. No byte reaches the engine, so the FIFO logic can be checked on its own. In configuration mode, offsets 0 and 1 return two read-only capability bytes.

Host accesses use a valid/ready request channel. A request is taken on any rising edge where `host_valid` and `host_ready` are both high. `host_ready` is low during reset and high at all other times, so the host never sees back-pressure once reset has ended. Each accepted read returns exactly one response: `rsp_valid` is high for one cycle on the next edge, and `rsp_data` carries the byte. Accepted writes return no response. The engine side has two streams, one into the FIFO and one out of it. Each moves a byte on an edge where its valid and its ready are both high. The block controls `eng_in_ready` and `eng_out_valid`, and both stay low except in data mode with the matching direction.

A write to a full FIFO is dropped, and so is a read from an empty FIFO. Neither case stalls the block. The FIFO is cleared by reset and on any clock edge where the mode input differs from its value at the previous edge.

Top module: `ecp_fifo_window`

## Requirements
- R1: In test mode (mode = 3'b110), a write to offset 0 pushes `host_wdata` and a read from offset 0 pops the oldest byte, with either value of `dir_rev`. Bytes come out in the order they were written: writing 44h, 33h, 22h, 11h reads back as 44h, 33h, 22h, 11h.
- R2: In test mode, `eng_in_ready` and `eng_out_valid` stay low, so no byte is exchanged with the transfer engine.
- R3: With 16 bytes held, `fifo_full` is high and a further write is dropped without changing the contents. A read from an empty FIFO returns 00h, changes nothing, and `fifo_empty` stays high.
- R4: In data mode (mode = 3'b011) with `dir_rev` = 0 (forward), host writes to offset 0 push bytes. The engine drains them in order through `eng_out_valid`/`eng_out_ready`/`eng_out_data`. A host read of offset 0 returns 00h and pops nothing.
- R5: In data mode with `dir_rev` = 1 (reverse), a host write to offset 0 is ignored. The engine fills the FIFO through `eng_in_valid`/`eng_in_ready`/`eng_in_data`, and host reads of offset 0 pop the bytes in order.
- R6: In configuration mode (mode = 3'b111), offset 0 reads {4'b0001, `cfg_flag`, 3'b100}. Offset 1 reads {1'b0, `irq_level`, `irq_sel`[2:0], `dma_sel`[2:0]}. Writes to either offset change nothing.
- R7: With any other mode value, a read of offset 0 returns 00h and a write to offset 0 pushes nothing.
- R8: Reset, and any change of the mode input, empty the FIFO: `fifo_empty` is high on the following cycle.
- R9: `pd_undef` is high exactly when the mode is test mode and `dir_rev` = 0. It marks the data-pin bus as holding no defined value.
- R10: `host_ready` is high from the first edge after reset is released. Every accepted read gives `rsp_valid` high for exactly one cycle on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Mode field from the extended control register |
| dir_rev | input | 1 | Direction: 0 forward (host to peripheral), 1 reverse |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block accepts host requests |
| host_wr | input | 1 | 1 write, 0 read |
| host_addr | input | 1 | Register offset (0 or 1) |
| host_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_data | output | 8 | Read response byte |
| eng_in_valid | input | 1 | Engine offers a byte to the FIFO |
| eng_in_ready | output | 1 | FIFO accepts an engine byte |
| eng_in_data | input | 8 | Engine byte into the FIFO |
| eng_out_valid | output | 1 | FIFO offers a byte to the engine |
| eng_out_ready | input | 1 | Engine takes the offered byte |
| eng_out_data | output | 8 | Oldest FIFO byte |
| fifo_full | output | 1 | FIFO holds DEPTH bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| pd_undef | output | 1 | Data-pin bus content undefined |
| cfg_flag | input | 1 | Spare configuration bit mirrored into offset 0 of configuration mode |
| irq_level | input | 1 | Sampled interrupt line level |
| irq_sel | input | 3 | Configured interrupt line code |
| dma_sel | input | 3 | Configured DMA channel code |

## Verification
The assertions assume that the mode and direction inputs change only between host accesses, and never in the same cycle as an access. They also assume the engine raises `eng_in_valid` or `eng_out_ready` only when the matching side of the handshake is offered. The bench changes mode and direction at falling edges when no request is pending. After each mode change it waits a full cycle before the next access, so the clear is never mixed with an access. It drives the engine streams only in data mode and checks the block's ready or valid before each handshake.

// File: rtl/ecp_win_pkg.sv
package ecp_win_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] MODE_DATA = 3'b011;
  localparam logic [2:0] MODE_TEST = 3'b110;
  localparam logic [2:0] MODE_CFG  = 3'b111;

  // Access routing produced by the mode decoder
  typedef struct packed {
    logic host_push;  // host write lands in the FIFO
    logic host_pop;   // host read takes the head byte
    logic fifo_rd;    // read data comes from the FIFO head
    logic cfg_rd;     // read data comes from the capability bytes
    logic eng_in_en;  // engine may fill the FIFO
    logic eng_out_en; // engine may drain the FIFO
  } route_t;
endpackage

// File: rtl/ecp_byte_fifo.sv
module ecp_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign full    = (count_q == CNT_MAX);
  assign empty   = (count_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R3: push into a full FIFO leaves it full with the write pointer still
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop && !clr |=> full && $stable(wr_ptr_q));

  // R3: pop from an empty FIFO leaves it empty
  a_r3_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push && !clr |=> empty && $stable(rd_ptr_q));

  // R8: clear empties the storage on the next cycle
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);

  // R1: an accepted lone push raises the fill count by one
  a_r1_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop && !full && !clr |=> count_q == $past(count_q) + 1'b1);
endmodule

// File: rtl/ecp_mode_decode.sv
module ecp_mode_decode
  import ecp_win_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       dir_rev,
  input  logic       acc_fire,
  input  logic       acc_wr,
  input  logic       acc_addr,
  output route_t     route,
  output logic       pd_undef
);
  logic is_data, is_test, is_cfg, fifo_wr_ok, fifo_rd_ok;

  assign is_data = (mode == MODE_DATA);
  assign is_test = (mode == MODE_TEST);
  assign is_cfg  = (mode == MODE_CFG);

  // Test mode ignores direction; data mode follows it
  assign fifo_wr_ok = is_test || (is_data && !dir_rev);
  assign fifo_rd_ok = is_test || (is_data && dir_rev);

  always_comb begin
    route            = '0;
    route.fifo_rd    = fifo_rd_ok && !acc_addr;
    route.cfg_rd     = is_cfg;
    route.host_push  = acc_fire && acc_wr && !acc_addr && fifo_wr_ok;
    route.host_pop   = acc_fire && !acc_wr && !acc_addr && fifo_rd_ok;
    route.eng_in_en  = is_data && dir_rev;
    route.eng_out_en = is_data && !dir_rev;
  end

  assign pd_undef = is_test && !dir_rev;

  // R9: undefined pin marker only in forward test mode
  a_r9_undef_only_fwd_test: assert property (@(posedge clk) disable iff (!rst_n)
    pd_undef |-> (mode == MODE_TEST) && !dir_rev);

  // R2: the engine is never enabled outside data mode
  a_r2_engine_only_data: assert property (@(posedge clk) disable iff (!rst_n)
    (route.eng_in_en || route.eng_out_en) |-> (mode == MODE_DATA));
endmodule

// File: rtl/ecp_cfg_regs.sv
module ecp_cfg_regs
  import ecp_win_pkg::*;
(
  input  logic              sel_b,
  input  logic              cfg_flag,
  input  logic              irq_level,
  input  logic [2:0]        irq_sel,
  input  logic [2:0]        dma_sel,
  output logic [BYTE_W-1:0] cfg_byte
);
  localparam logic [3:0] A_HIGH = 4'b0001;
  localparam logic [2:0] A_LOW  = 3'b100;

  logic [BYTE_W-1:0] reg_a, reg_b;

  assign reg_a    = {A_HIGH, cfg_flag, A_LOW};
  assign reg_b    = {1'b0, irq_level, irq_sel, dma_sel};
  assign cfg_byte = sel_b ? reg_b : reg_a;
endmodule

// File: rtl/ecp_fifo_window.sv
module ecp_fifo_window
  import ecp_win_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              dir_rev,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  input  logic              eng_in_valid,
  output logic              eng_in_ready,
  input  logic [BYTE_W-1:0] eng_in_data,
  output logic              eng_out_valid,
  input  logic              eng_out_ready,
  output logic [BYTE_W-1:0] eng_out_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic              pd_undef,
  input  logic              cfg_flag,
  input  logic              irq_level,
  input  logic [2:0]        irq_sel,
  input  logic [2:0]        dma_sel
);
  route_t            route;
  logic              acc_fire, mode_chg, eng_push, eng_pop;
  logic              fifo_push, fifo_pop;
  logic [2:0]        mode_q;
  logic [BYTE_W-1:0] head, cfg_byte, push_byte, rd_byte;

  assign acc_fire = host_valid && host_ready;
  assign mode_chg = (mode != mode_q);

  ecp_mode_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .dir_rev  (dir_rev),
    .acc_fire (acc_fire),
    .acc_wr   (host_wr),
    .acc_addr (host_addr),
    .route    (route),
    .pd_undef (pd_undef)
  );

  ecp_cfg_regs u_cfg (
    .sel_b     (host_addr),
    .cfg_flag  (cfg_flag),
    .irq_level (irq_level),
    .irq_sel   (irq_sel),
    .dma_sel   (dma_sel),
    .cfg_byte  (cfg_byte)
  );

  assign eng_in_ready  = route.eng_in_en && !fifo_full;
  assign eng_out_valid = route.eng_out_en && !fifo_empty;
  assign eng_out_data  = head;
  assign eng_push      = eng_in_valid && eng_in_ready;
  assign eng_pop       = eng_out_valid && eng_out_ready;

  assign fifo_push = route.host_push || eng_push;
  assign fifo_pop  = route.host_pop || eng_pop;
  assign push_byte = route.eng_in_en ? eng_in_data : host_wdata;

  ecp_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (mode_chg),
    .push      (fifo_push),
    .push_data (push_byte),
    .pop       (fifo_pop),
    .head      (head),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  always_comb begin
    if (route.fifo_rd)     rd_byte = fifo_empty ? '0 : head;
    else if (route.cfg_rd) rd_byte = cfg_byte;
    else                   rd_byte = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= '0;
      host_ready <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
    end else begin
      mode_q     <= mode;
      host_ready <= 1'b1;
      rsp_valid  <= acc_fire && !host_wr;
      if (acc_fire && !host_wr) rsp_data <= rd_byte;
    end
  end

  // R10: every accepted read is answered on the next edge
  a_r10_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !host_wr |=> rsp_valid);

  // R10: a write produces no response
  a_r10_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && host_wr |=> !rsp_valid);

  // R2: test mode never hands bytes to or from the engine
  a_r2_test_no_engine: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TEST) |-> !eng_in_ready && !eng_out_valid);

  // R8: a mode change leaves the FIFO empty
  a_r8_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> fifo_empty);
endmodule

// File: tb/test_ecp_fifo_window.sv
module test_ecp_fifo_window;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode;
  logic       dir_rev, host_valid, host_ready, host_wr, host_addr;
  logic [7:0] host_wdata, rsp_data, eng_in_data, eng_out_data;
  logic       rsp_valid, eng_in_valid, eng_in_ready, eng_out_valid, eng_out_ready;
  logic       fifo_full, fifo_empty, pd_undef, cfg_flag, irq_level;
  logic [2:0] irq_sel, dma_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ecp_fifo_window i_ecp_fifo_window (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dir_rev(dir_rev),
    .host_valid(host_valid), .host_ready(host_ready), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .eng_in_valid(eng_in_valid), .eng_in_ready(eng_in_ready), .eng_in_data(eng_in_data),
    .eng_out_valid(eng_out_valid), .eng_out_ready(eng_out_ready), .eng_out_data(eng_out_data),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .pd_undef(pd_undef),
    .cfg_flag(cfg_flag), .irq_level(irq_level), .irq_sel(irq_sel), .dma_sel(dma_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m, input logic d);
    @(negedge clk);
    mode    = m;
    dir_rev = d;
    @(negedge clk);
  endtask

  task automatic host_write(input logic a, input logic [7:0] v);
    @(negedge clk);
    host_valid = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_valid = 1'b0; host_wr = 1'b0;
  endtask

  task automatic host_read(input logic a, output logic [7:0] v, output logic vld);
    @(negedge clk);
    host_valid = 1'b1; host_wr = 1'b0; host_addr = a;
    @(negedge clk);
    host_valid = 1'b0;
    v   = rsp_data;
    vld = rsp_valid;
  endtask

  task automatic t_reset;
    chk("R8 reset empty", fifo_empty, 1);
    chk("R3 reset not full", fifo_full, 0);
    chk("R10 ready after reset", host_ready, 1);
    chk("R10 no response idle", rsp_valid, 0);
  endtask

  task automatic t_test_order;
    logic [7:0] v; logic vld;
    logic [7:0] pat [4] = '{8'h44, 8'h33, 8'h22, 8'h11};
    set_mode(3'b110, 1'b1);
    chk("R9 undef low in reverse test", pd_undef, 0);
    foreach (pat[i]) host_write(1'b0, pat[i]);
    chk("R2 no engine in test", {eng_in_ready, eng_out_valid}, 0);
    set_mode(3'b110, 1'b0);
    chk("R9 undef high in forward test", pd_undef, 1);
    chk("R2 no engine in forward test", {eng_in_ready, eng_out_valid}, 0);
    foreach (pat[i]) begin
      host_read(1'b0, v, vld);
      chk("R1 test order", v, pat[i]);
      chk("R10 response valid", vld, 1);
    end
    @(negedge clk);
    chk("R10 response one cycle", rsp_valid, 0);
    chk("R1 drained", fifo_empty, 1);
  endtask

  task automatic t_full_empty;
    logic [7:0] v; logic vld;
    set_mode(3'b000, 1'b0);
    set_mode(3'b110, 1'b1);
    for (int i = 0; i < 16; i++) host_write(1'b0, 8'(8'h80 + i));
    chk("R3 full at 16", fifo_full, 1);
    host_write(1'b0, 8'hEE);
    chk("R3 still full", fifo_full, 1);
    for (int i = 0; i < 16; i++) begin
      host_read(1'b0, v, vld);
      chk("R3 contents kept after overflow", v, 8'(8'h80 + i));
    end
    chk("R3 empty", fifo_empty, 1);
    host_read(1'b0, v, vld);
    chk("R3 underrun reads 00", v, 8'h00);
    chk("R3 underrun answered", vld, 1);
    chk("R3 still empty", fifo_empty, 1);
    host_write(1'b0, 8'h5A);
    host_read(1'b0, v, vld);
    chk("R3 usable after underrun", v, 8'h5A);
  endtask

  task automatic t_data_fwd;
    logic [7:0] v; logic vld;
    set_mode(3'b011, 1'b0);
    chk("R4 engine out idle when empty", eng_out_valid, 0);
    host_write(1'b0, 8'hA1);
    host_write(1'b0, 8'hA2);
    host_read(1'b0, v, vld);
    chk("R4 forward read returns 00", v, 8'h00);
    chk("R4 engine in closed forward", eng_in_ready, 0);
    chk("R4 first offered valid", eng_out_valid, 1);
    chk("R4 first offered byte kept", eng_out_data, 8'hA1);
    eng_out_ready = 1'b1;
    @(negedge clk);
    chk("R4 second offered byte", eng_out_data, 8'hA2);
    @(negedge clk);
    eng_out_ready = 1'b0;
    chk("R4 drained by engine", fifo_empty, 1);
    chk("R4 nothing offered", eng_out_valid, 0);
  endtask

  task automatic t_data_rev;
    logic [7:0] v; logic vld;
    set_mode(3'b011, 1'b1);
    host_write(1'b0, 8'h55);
    chk("R5 reverse write ignored", fifo_empty, 1);
    chk("R5 engine in open", eng_in_ready, 1);
    chk("R5 engine out closed", eng_out_valid, 0);
    eng_in_valid = 1'b1; eng_in_data = 8'h66;
    @(negedge clk);
    eng_in_data = 8'h77;
    @(negedge clk);
    eng_in_valid = 1'b0;
    host_read(1'b0, v, vld);
    chk("R5 first reverse byte", v, 8'h66);
    host_read(1'b0, v, vld);
    chk("R5 second reverse byte", v, 8'h77);
    chk("R5 empty after reads", fifo_empty, 1);
  endtask

  task automatic t_cfg;
    logic [7:0] v; logic vld;
    cfg_flag = 1'b1; irq_level = 1'b1; irq_sel = 3'd5; dma_sel = 3'd3;
    set_mode(3'b111, 1'b0);
    host_read(1'b0, v, vld);
    chk("R6 cfg A", v, 8'h1C);
    host_read(1'b1, v, vld);
    chk("R6 cfg B", v, 8'h6B);
    host_write(1'b0, 8'hFF);
    host_write(1'b1, 8'h00);
    chk("R6 write does not fill FIFO", fifo_empty, 1);
    host_read(1'b0, v, vld);
    chk("R6 cfg A after write", v, 8'h1C);
    host_read(1'b1, v, vld);
    chk("R6 cfg B after write", v, 8'h6B);
    cfg_flag = 1'b0; irq_level = 1'b0; irq_sel = 3'd2; dma_sel = 3'd6;
    host_read(1'b0, v, vld);
    chk("R6 cfg A flag clear", v, 8'h14);
    host_read(1'b1, v, vld);
    chk("R6 cfg B new codes", v, 8'h16);
  endtask

  task automatic t_other;
    logic [7:0] v; logic vld;
    set_mode(3'b001, 1'b1);
    host_write(1'b0, 8'h99);
    chk("R7 write pushes nothing", fifo_empty, 1);
    host_read(1'b0, v, vld);
    chk("R7 read returns 00", v, 8'h00);
    chk("R2 engine idle in other mode", {eng_in_ready, eng_out_valid}, 0);
  endtask

  task automatic t_clear;
    set_mode(3'b110, 1'b0);
    host_write(1'b0, 8'h01);
    host_write(1'b0, 8'h02);
    chk("R8 holds bytes", fifo_empty, 0);
    set_mode(3'b011, 1'b0);
    chk("R8 mode change clears", fifo_empty, 1);
    host_write(1'b0, 8'h03);
    chk("R8 holds byte before reset", fifo_empty, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset clears", fifo_empty, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 3'b000; dir_rev = 1'b0;
    host_valid = 1'b0; host_wr = 1'b0; host_addr = 1'b0; host_wdata = '0;
    eng_in_valid = 1'b0; eng_in_data = '0; eng_out_ready = 1'b0;
    cfg_flag = 1'b0; irq_level = 1'b0; irq_sel = '0; dma_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_test_order();
    t_full_empty();
    t_data_fwd();
    t_data_rev();
    t_cfg();
    t_other();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule